// File: doc/BRIEF.md
# Single-Wire Bus Slave Front End

This block is the digital front end of a slave on a single-wire, open-drain, multidrop bus with one master. It takes the raw bus line, passes it through a two-stage synchronizer, and drives a single pull-down enable back to the pad. It never drives the line high. A microsecond tick from a clock divider runs every timer. The divider restarts on each line transition, so all timing is measured from the edge that the master drives.

A reset is a low level that lasts longer than a speed-dependent threshold. After a reset the block waits for the line to be released and then answers with a presence pulse. It then follows the transaction phases in a fixed order: a ROM command byte, then a memory command byte, then data. Each master time slot begins on a falling edge. The block samples the line a fixed time after that edge. It reports every bit and every completed byte to the layer above, least significant bit first. In the data phase, that layer may ask for a zero reply. The block then holds the line low for a hold time. An overdrive request switches every threshold to the short set. A reset of regular length returns the block to regular speed.

Top module: `sw_slave_front`

## Requirements
- R1: After `rst_n` is released, `bus_pull` is 0, `phase` is 0 (initialization) and `od_mode` is 0.
- R2: At regular speed, a low level lasting RST_STD_US microseconds produces a one-cycle `bus_rst` pulse and returns `phase` to 0. A low level of 100 µs produces no pulse.
- R3: A one-cycle pulse on `od_set` sets `od_mode`. While `od_mode` is 1, a low level of RST_OD_US microseconds is enough to signal a reset.
- R4: A low level of RST_STD_US microseconds clears `od_mode`. A shorter reset in overdrive leaves `od_mode` set.
- R5: After a reset, once the line returns high, the block asserts `bus_pull` for PRES_STD_US microseconds (PRES_OD_US in overdrive) and then releases it. `phase` then becomes 1.
- R6: In phases 1 to 3, each falling edge starts a slot. SAMP_STD_US (or SAMP_OD_US) microseconds later, the line is sampled and reported on `rx_bit` with a one-cycle `rx_valid`.
- R7: Bits are assembled least significant bit first. Every eighth bit since the last reset raises `byte_valid` for one cycle, with the assembled value on `rx_byte`.
- R8: `phase` encodes 0 = initialization, 1 = ROM command, 2 = memory command, 3 = data. It advances by one after each completed byte in phases 1 and 2, stays at 3 in the data phase, and otherwise changes only to 0 on a reset.
- R9: In phase 3, a slot that starts while `reply_en` is 1 and `reply_bit` is 0 holds `bus_pull` for HOLD_STD_US (or HOLD_OD_US) microseconds. If `reply_bit` is 1, `bus_pull` stays 0.
- R10: `reply_en` has no effect outside phase 3, and `bus_pull` stays 0 during those slots.
- R11: In phase 0, falling edges start no slot and produce no `rx_valid`.
- R12: A long idle-high period in the middle of a byte keeps the received bits and the bit count. The byte completes with the following slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_in | input | 1 | Raw bus line level (asynchronous) |
| bus_pull | output | 1 | Open-drain enable: 1 pulls the line low |
| od_set | input | 1 | Pulse: switch to the overdrive timing set |
| od_mode | output | 1 | Overdrive timing set is active |
| phase | output | 2 | Transaction phase: 0 init, 1 ROM cmd, 2 memory cmd, 3 data |
| bus_rst | output | 1 | One-cycle pulse on a detected bus reset |
| rx_valid | output | 1 | One-cycle pulse: `rx_bit` holds a new bit |
| rx_bit | output | 1 | Most recently sampled slot bit |
| byte_valid | output | 1 | One-cycle pulse: `rx_byte` holds a completed byte |
| rx_byte | output | 8 | Most recently completed byte, first bit in bit 0 |
| reply_en | input | 1 | Upper layer requests a reply in the next slot |
| reply_bit | input | 1 | Reply value; 0 causes the line to be held low |

## Verification
The assertions assume that the master keeps every slot low time below the active reset threshold. They also assume it leaves the line high long enough after each slot for the block to return to idle before the next falling edge. The assertions further assume that `od_set` is not pulsed during a regular-length reset. The stimulus holds write-zero slots low for 60 µs (regular) and 8 µs (overdrive), with slot periods of 70 µs and 12 µs. This stays clear of the 120 µs and 16 µs thresholds and covers the longest hold. The bus model combines the master's pull with `bus_pull` as a wired AND, so the block sees its own presence and reply pulses on the line.

// File: rtl/sw_slave_front.sv
`timescale 1ns/1ps
module sw_slave_front #(
  parameter int CLK_DIV     = 100,
  parameter int RST_STD_US  = 120,
  parameter int RST_OD_US   = 16,
  parameter int PRES_STD_US = 60,
  parameter int PRES_OD_US  = 8,
  parameter int SAMP_STD_US = 15,
  parameter int SAMP_OD_US  = 2,
  parameter int HOLD_STD_US = 30,
  parameter int HOLD_OD_US  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_in,
  output logic       bus_pull,
  input  logic       od_set,
  output logic       od_mode,
  output logic [1:0] phase,
  output logic       bus_rst,
  output logic       rx_valid,
  output logic       rx_bit,
  output logic       byte_valid,
  output logic [7:0] rx_byte,
  input  logic       reply_en,
  input  logic       reply_bit
);
  localparam int DW      = $clog2(CLK_DIV);
  localparam int LW      = $clog2(RST_STD_US + 1);
  localparam int END_STD = (SAMP_STD_US > HOLD_STD_US) ? SAMP_STD_US : HOLD_STD_US;
  localparam int END_OD  = (SAMP_OD_US > HOLD_OD_US) ? SAMP_OD_US : HOLD_OD_US;
  localparam int TMAX    = (PRES_STD_US > END_STD) ? PRES_STD_US : END_STD;
  localparam int TW      = $clog2(TMAX + 1);

  localparam logic [1:0] P_INIT = 2'd0;
  localparam logic [1:0] P_ROM  = 2'd1;
  localparam logic [1:0] P_DATA = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_WAITHI, S_PRES, S_SLOT} st_t;
  st_t st;

  logic s1, s2, s3;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, s3} <= 3'b111;
    else begin
      s1 <= bus_in;
      s2 <= s1;
      s3 <= s2;
    end

  wire fall  = s3 & ~s2;
  wire rise  = ~s3 & s2;
  wire trans = s3 ^ s2;

  logic [DW-1:0] div;
  wire tick = (div == DW'(CLK_DIV - 1)) & ~trans;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div <= '0;
    else if (trans || div == DW'(CLK_DIV - 1)) div <= '0;
    else div <= div + 1'b1;

  logic [LW-1:0] low_us;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) low_us <= '0;
    else if (s2 || st == S_PRES) low_us <= '0;
    else if (tick && low_us != LW'(RST_STD_US)) low_us <= low_us + 1'b1;

  wire [LW-1:0] thr_lim = od_mode ? LW'(RST_OD_US - 1) : LW'(RST_STD_US - 1);
  wire low_run = tick & ~s2 & (st != S_PRES);
  wire hit_std = low_run & (low_us == LW'(RST_STD_US - 1));
  wire rst_hit = hit_std | (low_run & (low_us == thr_lim));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) od_mode <= 1'b0;
    else if (hit_std) od_mode <= 1'b0;
    else if (od_set) od_mode <= 1'b1;

  wire [TW-1:0] pres_lim = od_mode ? TW'(PRES_OD_US - 1) : TW'(PRES_STD_US - 1);
  wire [TW-1:0] samp_lim = od_mode ? TW'(SAMP_OD_US - 1) : TW'(SAMP_STD_US - 1);
  wire [TW-1:0] end_lim  = od_mode ? TW'(END_OD - 1)     : TW'(END_STD - 1);
  wire [TW-1:0] hold_len = od_mode ? TW'(HOLD_OD_US)     : TW'(HOLD_STD_US);

  logic [TW-1:0] tmr;
  logic          drv_zero;
  logic [2:0]    bcnt;
  logic [7:0]    sh;
  wire  [7:0]    sh_nxt = {s2, sh[7:1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st         <= S_IDLE;
      phase      <= P_INIT;
      tmr        <= '0;
      drv_zero   <= 1'b0;
      bcnt       <= '0;
      sh         <= '0;
      bus_rst    <= 1'b0;
      rx_valid   <= 1'b0;
      rx_bit     <= 1'b0;
      byte_valid <= 1'b0;
      rx_byte    <= '0;
    end else begin
      rx_valid   <= 1'b0;
      byte_valid <= 1'b0;
      bus_rst    <= rst_hit;
      if (rst_hit) begin
        st       <= S_WAITHI;
        phase    <= P_INIT;
        bcnt     <= '0;
        drv_zero <= 1'b0;
      end else begin
        case (st)
          S_IDLE:
            if (fall && phase != P_INIT) begin
              st       <= S_SLOT;
              tmr      <= '0;
              drv_zero <= reply_en & ~reply_bit & (phase == P_DATA);
            end
          S_WAITHI:
            if (rise) begin
              st  <= S_PRES;
              tmr <= '0;
            end
          S_PRES:
            if (tick) begin
              if (tmr == pres_lim) begin
                st    <= S_IDLE;
                phase <= P_ROM;
              end else tmr <= tmr + 1'b1;
            end
          S_SLOT:
            if (tick) begin
              tmr <= tmr + 1'b1;
              if (tmr == samp_lim) begin
                rx_valid <= 1'b1;
                rx_bit   <= s2;
                sh       <= sh_nxt;
                bcnt     <= bcnt + 3'd1;
                if (bcnt == 3'd7) begin
                  byte_valid <= 1'b1;
                  rx_byte    <= sh_nxt;
                  if (phase != P_DATA) phase <= phase + 2'd1;
                end
              end
              if (tmr == end_lim) begin
                st       <= S_IDLE;
                drv_zero <= 1'b0;
              end
            end
          default: st <= S_IDLE;
        endcase
      end
    end

  assign bus_pull = (st == S_PRES) | ((st == S_SLOT) & drv_zero & (tmr < hold_len));

  // R8
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != $past(phase)) |-> (phase == 2'($past(phase) + 2'd1) || phase == P_INIT));
  // R10
  reply_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_pull && st == S_SLOT) |-> phase == P_DATA);
  // R4
  od_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(od_mode) |-> bus_rst);
  // R7
  byte_with_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> rx_valid);
  // R2
  rst_to_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |-> (phase == P_INIT && !bus_pull));
  // R11
  init_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_INIT) |-> !rx_valid);
endmodule

// File: tb/sw_slave_front_test.sv
`timescale 1ns/1ps
module sw_slave_front_test;
  localparam int CD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_low = 1'b0;
  logic od_set = 1'b0, reply_en = 1'b0, reply_bit = 1'b1;
  logic bus_pull, od_mode, bus_rst, rx_valid, rx_bit, byte_valid;
  logic [1:0] phase;
  logic [7:0] rx_byte;
  wire bus_in = ~(m_low | bus_pull);

  always #5 clk = ~clk;

  sw_slave_front #(.CLK_DIV(CD)) uut (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_pull(bus_pull),
    .od_set(od_set), .od_mode(od_mode), .phase(phase), .bus_rst(bus_rst),
    .rx_valid(rx_valid), .rx_bit(rx_bit), .byte_valid(byte_valid),
    .rx_byte(rx_byte), .reply_en(reply_en), .reply_bit(reply_bit));

  int n_chk = 0, n_bad = 0;
  int rx_n = 0, byte_n = 0, rst_cnt = 0;
  logic last_bit = 1'b0;
  logic [7:0] last_byte = '0;
  bit done = 1'b0;

  always @(negedge clk) if (rst_n) begin
    if (rx_valid) begin rx_n++; last_bit = rx_bit; end
    if (byte_valid) begin byte_n++; last_byte = rx_byte; end
    if (bus_rst) rst_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_us(input int n);
    repeat (n * CD) @(negedge clk);
  endtask

  task automatic low_for(input int n);
    @(negedge clk) m_low = 1'b1;
    wait_us(n);
    m_low = 1'b0;
  endtask

  task automatic wbit(input bit b, input bit od);
    int lo = od ? (b ? 1 : 8) : (b ? 6 : 60);
    int tot = od ? 12 : 70;
    low_for(lo);
    wait_us(tot - lo);
  endtask

  task automatic wbyte(input logic [7:0] v, input bit od);
    for (int i = 0; i < 8; i++) wbit(v[i], od);
  endtask

  task automatic presence(output int len);
    int w = 0;
    len = 0;
    while (!bus_pull && w < 100) begin @(negedge clk); w++; end
    while (bus_pull && len < 2000) begin @(negedge clk); len++; end
    wait_us(5);
  endtask

  task automatic bus_reset(input int n, output int plen);
    low_for(n);
    presence(plen);
  endtask

  task automatic rslot(input bit od, output int pulls);
    pulls = 0;
    @(negedge clk) m_low = 1'b1;
    wait_us(1);
    m_low = 1'b0;
    for (int i = 0; i < (od ? 11 : 69) * CD; i++) begin
      @(negedge clk);
      if (bus_pull) pulls++;
    end
  endtask

  function automatic bit near(input int a, input int e);
    return (a >= e - 6) && (a <= e + 6);
  endfunction

  task automatic t_reset_state;
    chk(bus_pull == 1'b0, "R1 pull", bus_pull, 0);
    chk(phase == 2'd0, "R1 phase", phase, 0);
    chk(od_mode == 1'b0, "R1 od", od_mode, 0);
  endtask

  task automatic t_init_ignore;
    int r0 = rx_n;
    wbit(1'b0, 1'b0);
    wbit(1'b1, 1'b0);
    chk(rx_n == r0, "R11 no slot in init", rx_n - r0, 0);
    chk(phase == 2'd0, "R11 phase", phase, 0);
  endtask

  task automatic t_std_reset;
    int c0 = rst_cnt, pl;
    bus_reset(130, pl);
    chk(rst_cnt == c0 + 1, "R2 reset pulse", rst_cnt - c0, 1);
    chk(near(pl, 60 * CD), "R5 presence std", pl, 60 * CD);
    chk(phase == 2'd1, "R5 phase ROM", phase, 1);
  endtask

  task automatic t_short_low;
    int c0 = rst_cnt, pl;
    low_for(100);
    wait_us(20);
    chk(rst_cnt == c0, "R2 short low", rst_cnt - c0, 0);
    chk(phase == 2'd1, "R2 phase kept", phase, 1);
    bus_reset(130, pl);
  endtask

  task automatic t_bytes;
    wbit(1'b0, 1'b0);
    chk(last_bit == 1'b0, "R6 bit0", last_bit, 0);
    wbit(1'b0, 1'b0);
    wbit(1'b1, 1'b0);
    chk(last_bit == 1'b1, "R6 bit1", last_bit, 1);
    wbit(1'b1, 1'b0);
    wbit(1'b1, 1'b0); wbit(1'b1, 1'b0); wbit(1'b0, 1'b0); wbit(1'b0, 1'b0);
    chk(last_byte == 8'h3C, "R7 ROM byte", last_byte, 8'h3C);
    chk(phase == 2'd2, "R8 to MEM", phase, 2);
    wbyte(8'hF0, 1'b0);
    chk(last_byte == 8'hF0, "R7 MEM byte", last_byte, 8'hF0);
    chk(phase == 2'd3, "R8 to DATA", phase, 3);
    wbyte(8'h81, 1'b0);
    chk(last_byte == 8'h81, "R7 DATA byte", last_byte, 8'h81);
    chk(phase == 2'd3, "R8 stays DATA", phase, 3);
  endtask

  task automatic t_reply;
    int p;
    reply_en = 1'b1; reply_bit = 1'b0;
    rslot(1'b0, p);
    chk(near(p, 30 * CD - 1), "R9 hold std", p, 30 * CD - 1);
    reply_bit = 1'b1;
    rslot(1'b0, p);
    chk(p == 0, "R9 reply one", p, 0);
    reply_en = 1'b0;
    bus_reset(130, p);
    reply_en = 1'b1; reply_bit = 1'b0;
    rslot(1'b0, p);
    chk(p == 0, "R10 no reply in ROM", p, 0);
    reply_en = 1'b0; reply_bit = 1'b1;
    bus_reset(130, p);
  endtask

  task automatic t_suspend;
    for (int i = 0; i < 4; i++) wbit(i[0], 1'b0);
    wait_us(500);
    chk(phase == 2'd1, "R12 phase held", phase, 1);
    for (int i = 4; i < 8; i++) wbit(~i[0], 1'b0);
    chk(last_byte == 8'h5A, "R12 byte", last_byte, 8'h5A);
    chk(phase == 2'd2, "R12 phase", phase, 2);
  endtask

  task automatic t_overdrive;
    int c0, pl, p;
    @(negedge clk) od_set = 1'b1;
    @(negedge clk) od_set = 1'b0;
    chk(od_mode == 1'b1, "R3 od set", od_mode, 1);
    c0 = rst_cnt;
    bus_reset(20, pl);
    chk(rst_cnt == c0 + 1, "R3 od reset", rst_cnt - c0, 1);
    chk(od_mode == 1'b1, "R4 od kept", od_mode, 1);
    chk(near(pl, 8 * CD), "R5 presence od", pl, 8 * CD);
    wbyte(8'hC3, 1'b1);
    chk(last_byte == 8'hC3, "R6 od byte", last_byte, 8'hC3);
    wbyte(8'h00, 1'b1);
    chk(phase == 2'd3, "R8 od DATA", phase, 3);
    reply_en = 1'b1; reply_bit = 1'b0;
    rslot(1'b1, p);
    chk(near(p, 4 * CD - 1), "R9 hold od", p, 4 * CD - 1);
    reply_en = 1'b0; reply_bit = 1'b1;
    c0 = rst_cnt;
    bus_reset(130, pl);
    chk(od_mode == 1'b0, "R4 od cleared", od_mode, 0);
    chk(rst_cnt > c0, "R4 reset seen", rst_cnt - c0, 1);
    chk(near(pl, 60 * CD), "R5 presence back to std", pl, 60 * CD);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_state;
    t_init_ignore;
    t_std_reset;
    t_short_low;
    t_bytes;
    t_reply;
    t_suspend;
    t_overdrive;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule